// File: doc/BRIEF.md
# Logical Device Resource Register Bank

This block holds the resource settings of one logical device inside a plug-and-play I/O controller. The settings are an enable for the device, a test mode that answers probe reads, a base I/O address, an interrupt line number and a DMA channel. Host software programs them through an index/data configuration path. That path is only open while the configuration enable input is high. A port-level decoder watches host I/O reads. It reports whether each read belongs to the device, which then takes the access, or to the test mode, which answers with a fixed byte.

The device window is eight bytes long and starts at the programmed base. In test mode the block answers reads in that window with one of two bytes, 0x55 or 0xAA. This lets software confirm that an address range is free before it turns the device on. The block refuses to start test mode while the device is enabled. It also refuses interrupt codes that name no usable line.

Top module: `ldev_cfg_bank`

## Requirements
- R1: After reset, configuration reads return 0x00 at index 0x30, 0x31 and 0x70 and 0x01 at index 0x74. Also after reset, `irq_en_o` is 0 and `dma_ch_o` is 1.
- R2: Index 0x30 bit 0 turns the device on. While it is on, an I/O read in the window sets `dev_fwd_o` one cycle later, together with `io_vld_o`, and `chk_resp_o` stays 0.
- R3: Index 0x31 bit 1 turns test mode on and bit 0 picks the pattern. When bit 0 is 1 the pattern is 0x55, and when it is 0 the pattern is 0xAA. While the device is off and test mode is on, a read in the window sets `chk_resp_o` one cycle later, with the pattern on `chk_data_o`.
- R4: While the device is on, a write to index 0x31 with bit 1 set is ignored entirely. A test response never follows a read that was made while the device was on.
- R5: The base address is assembled from two registers. Index 0x60 bits [3:0] give A[11:8]. Index 0x61 bits [7:3] give A[7:3], and bits [2:0] of 0x61 always read back as 0. The window covers base to base+7.
- R6: A base address below 0x100 decodes no read.
- R7: No read is decoded unless the device is on or test mode is on.
- R8: Index 0x70 bits [3:0] hold the interrupt code. Codes 3 to 11 drive `irq_num_o` and set `irq_en_o`. Code 0 clears `irq_en_o`. Codes 1, 2 and 12 to 15 are ignored, and the previous value is kept.
- R9: Index 0x71 always reads 0x02, which means edge-triggered, and writes to it are ignored. Unassigned indices read 0x00.
- R10: Index 0x74 bits [2:0] hold the DMA channel, which also drives `dma_ch_o`. The upper bits read as 0.
- R11: An I/O read and a configuration write in the same cycle are judged on the settings as they stood before that write.
- R12: Configuration writes made while `cfg_en_i` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Configuration path open |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 8 | Configuration register index |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Readback of the indexed register (0 when the path is closed) |
| io_rd_i | input | 1 | Host I/O read strobe |
| io_addr_i | input | 12 | Host I/O address |
| io_vld_o | output | 1 | An I/O read was judged in the previous cycle |
| dev_fwd_o | output | 1 | That read belongs to the device |
| chk_resp_o | output | 1 | That read is answered by the test pattern |
| chk_data_o | output | 8 | Test pattern byte |
| irq_en_o | output | 1 | A valid interrupt line is selected |
| irq_num_o | output | 4 | Selected interrupt code |
| dma_ch_o | output | 3 | Selected DMA channel |

## Verification
Two functions can fall in the same cycle: a configuration write that changes the device enable or test mode, and an I/O read in the window. The bench provokes this by driving a write to index 0x30 and a window read on the same clock edge. The expected result is taken from the settings in force before the write, which gives a test-pattern answer rather than a device access. The following read is then expected to reach the device.

// File: rtl/ldev_cfg_pkg.sv
package ldev_cfg_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned ALIGN_W = 3;
  localparam int unsigned IRQ_W   = 4;
  localparam int unsigned DMA_W   = 3;
  localparam int unsigned HI_W    = ADDR_W - 8;

  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_RCHK    = 8'h31;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] IDX_IRQ     = 8'h70;
  localparam logic [7:0] IDX_ITYPE   = 8'h71;
  localparam logic [7:0] IDX_DMA     = 8'h74;

  typedef struct packed {
    logic                        act;
    logic                        rc_en;
    logic                        rc_pat;
    logic [ADDR_W-1:ALIGN_W]     base;
    logic [IRQ_W-1:0]            irq;
    logic [DMA_W-1:0]            dma;
  } ldev_cfg_t;
endpackage

// File: rtl/ldev_reg_file.sv
module ldev_reg_file
  import ldev_cfg_pkg::*;
#(
  parameter int unsigned IRQ_LO  = 3,
  parameter int unsigned IRQ_HI  = 11,
  parameter int unsigned DMA_RST = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ldev_cfg_t         cfg_o
);
  localparam logic [IRQ_W-1:0] IRQ_LO_C  = IRQ_W'(IRQ_LO);
  localparam logic [IRQ_W-1:0] IRQ_HI_C  = IRQ_W'(IRQ_HI);
  localparam logic [DMA_W-1:0] DMA_RST_C = DMA_W'(DMA_RST);

  ldev_cfg_t        cfg_q;
  logic [IRQ_W-1:0] irq_code;
  logic             irq_ok;
  logic             rchk_ok;

  assign irq_code = wdata_i[IRQ_W-1:0];
  assign irq_ok   = (irq_code == '0) || ((irq_code >= IRQ_LO_C) && (irq_code <= IRQ_HI_C));
  // test mode may only be switched on while the device is off
  assign rchk_ok  = !cfg_q.act || !wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      cfg_q.dma <= DMA_RST_C;
    end else if (wr_i) begin
      case (idx_i)
        IDX_ACT:     cfg_q.act <= wdata_i[0];
        IDX_RCHK: begin
          if (rchk_ok) begin
            cfg_q.rc_en  <= wdata_i[1];
            cfg_q.rc_pat <= wdata_i[0];
          end
        end
        IDX_BASE_HI: cfg_q.base[ADDR_W-1:8] <= wdata_i[HI_W-1:0];
        IDX_BASE_LO: cfg_q.base[7:ALIGN_W]  <= wdata_i[7:ALIGN_W];
        IDX_IRQ:     if (irq_ok) cfg_q.irq <= irq_code;
        IDX_DMA:     cfg_q.dma <= wdata_i[DMA_W-1:0];
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/ldev_rdmux.sv
module ldev_rdmux
  import ldev_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] ITYPE_VAL = 8'h02
) (
  input  logic              en_i,
  input  logic [7:0]        idx_i,
  input  ldev_cfg_t         cfg_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (en_i) begin
      case (idx_i)
        IDX_ACT:     rdata_o = {{(DATA_W-1){1'b0}}, cfg_i.act};
        IDX_RCHK:    rdata_o = {{(DATA_W-2){1'b0}}, cfg_i.rc_en, cfg_i.rc_pat};
        IDX_BASE_HI: rdata_o = {{(DATA_W-HI_W){1'b0}}, cfg_i.base[ADDR_W-1:8]};
        IDX_BASE_LO: rdata_o = {cfg_i.base[7:ALIGN_W], {ALIGN_W{1'b0}}};
        IDX_IRQ:     rdata_o = {{(DATA_W-IRQ_W){1'b0}}, cfg_i.irq};
        IDX_ITYPE:   rdata_o = ITYPE_VAL;
        IDX_DMA:     rdata_o = {{(DATA_W-DMA_W){1'b0}}, cfg_i.dma};
        default:     rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ldev_io_decode.sv
module ldev_io_decode
  import ldev_cfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_MIN = 12'h100,
  parameter logic [DATA_W-1:0] PAT_SET  = 8'h55,
  parameter logic [DATA_W-1:0] PAT_CLR  = 8'hAA
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    act_i,
  input  logic                    rc_en_i,
  input  logic                    rc_pat_i,
  input  logic [ADDR_W-1:ALIGN_W] base_i,
  output logic                    vld_o,
  output logic                    fwd_o,
  output logic                    resp_o,
  output logic [DATA_W-1:0]       data_o
);
  logic base_ok, hit, fwd_d, resp_d;

  assign base_ok = base_i >= BASE_MIN[ADDR_W-1:ALIGN_W];
  assign hit     = rd_i && base_ok && (act_i || rc_en_i) &&
                   (addr_i[ADDR_W-1:ALIGN_W] == base_i);
  assign fwd_d   = hit && act_i;
  assign resp_d  = hit && !act_i && rc_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      fwd_o  <= 1'b0;
      resp_o <= 1'b0;
      data_o <= '0;
    end else begin
      vld_o  <= rd_i;
      fwd_o  <= fwd_d;
      resp_o <= resp_d;
      data_o <= resp_d ? (rc_pat_i ? PAT_SET : PAT_CLR) : '0;
    end
  end
endmodule

// File: rtl/ldev_cfg_bank.sv
module ldev_cfg_bank
  import ldev_cfg_pkg::*;
#(
  parameter int unsigned       IRQ_LO    = 3,
  parameter int unsigned       IRQ_HI    = 11,
  parameter int unsigned       DMA_RST   = 1,
  parameter logic [ADDR_W-1:0] BASE_MIN  = 12'h100,
  parameter logic [DATA_W-1:0] PAT_SET   = 8'h55,
  parameter logic [DATA_W-1:0] PAT_CLR   = 8'hAA,
  parameter logic [DATA_W-1:0] ITYPE_VAL = 8'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_wr_i,
  input  logic [7:0]        cfg_idx_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              io_rd_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  output logic              io_vld_o,
  output logic              dev_fwd_o,
  output logic              chk_resp_o,
  output logic [DATA_W-1:0] chk_data_o,
  output logic              irq_en_o,
  output logic [IRQ_W-1:0]  irq_num_o,
  output logic [DMA_W-1:0]  dma_ch_o
);
  ldev_cfg_t cfg_q;
  logic      dev_act, rc_on;

  assign dev_act = cfg_q.act;
  assign rc_on   = cfg_q.rc_en;

  ldev_reg_file #(.IRQ_LO(IRQ_LO), .IRQ_HI(IRQ_HI), .DMA_RST(DMA_RST)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i && cfg_en_i),
    .idx_i   (cfg_idx_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg_q)
  );

  ldev_rdmux #(.ITYPE_VAL(ITYPE_VAL)) u_rdmux (
    .en_i    (cfg_en_i),
    .idx_i   (cfg_idx_i),
    .cfg_i   (cfg_q),
    .rdata_o (cfg_rdata_o)
  );

  ldev_io_decode #(.BASE_MIN(BASE_MIN), .PAT_SET(PAT_SET), .PAT_CLR(PAT_CLR)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (io_rd_i),
    .addr_i   (io_addr_i),
    .act_i    (dev_act),
    .rc_en_i  (rc_on),
    .rc_pat_i (cfg_q.rc_pat),
    .base_i   (cfg_q.base),
    .vld_o    (io_vld_o),
    .fwd_o    (dev_fwd_o),
    .resp_o   (chk_resp_o),
    .data_o   (chk_data_o)
  );

  assign irq_en_o  = cfg_q.irq != '0;
  assign irq_num_o = cfg_q.irq;
  assign dma_ch_o  = cfg_q.dma;
endmodule

// File: rtl/ldev_cfg_chk.sv
module ldev_cfg_chk #(
  parameter logic [7:0] PAT_SET = 8'h55,
  parameter logic [7:0] PAT_CLR = 8'hAA,
  parameter int unsigned IRQ_LO = 3,
  parameter int unsigned IRQ_HI = 11
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_en_i,
  input logic [7:0] cfg_idx_i,
  input logic [7:0] cfg_rdata_o,
  input logic       io_vld_o,
  input logic       dev_fwd_o,
  input logic       chk_resp_o,
  input logic [7:0] chk_data_o,
  input logic       irq_en_o,
  input logic [3:0] irq_num_o,
  input logic       dev_act,
  input logic       rc_on
);
  assert_fwd_resp_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dev_fwd_o, chk_resp_o}));

  assert_resp_pattern_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_resp_o |-> (chk_data_o == PAT_SET || chk_data_o == PAT_CLR));

  assert_no_resp_when_on_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_resp_o |-> !$past(dev_act));

  assert_rchk_start_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rc_on) |-> !$past(dev_act));

  assert_lsb_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_i && cfg_idx_i == 8'h61) |-> (cfg_rdata_o[2:0] == 3'b000));

  assert_decode_needs_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_fwd_o || chk_resp_o) |-> io_vld_o);

  assert_irq_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en_o |-> (irq_num_o >= 4'(IRQ_LO) && irq_num_o <= 4'(IRQ_HI)));
endmodule

bind ldev_cfg_bank ldev_cfg_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_en_i    (cfg_en_i),
  .cfg_idx_i   (cfg_idx_i),
  .cfg_rdata_o (cfg_rdata_o),
  .io_vld_o    (io_vld_o),
  .dev_fwd_o   (dev_fwd_o),
  .chk_resp_o  (chk_resp_o),
  .chk_data_o  (chk_data_o),
  .irq_en_o    (irq_en_o),
  .irq_num_o   (irq_num_o),
  .dev_act     (dev_act),
  .rc_on       (rc_on)
);

// File: tb/tb_ldev_cfg_bank.sv
`timescale 1ns/1ps
module tb_ldev_cfg_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_en_i = 1'b1, cfg_wr_i = 1'b0;
  logic [7:0]  cfg_idx_i = '0, cfg_wdata_i = '0, cfg_rdata_o;
  logic        io_rd_i = 1'b0;
  logic [11:0] io_addr_i = '0;
  logic        io_vld_o, dev_fwd_o, chk_resp_o, irq_en_o;
  logic [7:0]  chk_data_o;
  logic [3:0]  irq_num_o;
  logic [2:0]  dma_ch_o;

  int n_vec = 0, n_bad = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #4 clk_i = ~clk_i;

  ldev_cfg_bank dut (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] idx, logic [7:0] data);
    @(negedge clk_i);
    cfg_wr_i = 1'b1; cfg_idx_i = idx; cfg_wdata_i = data;
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
  endtask

  task automatic cfg_read(string tag, logic [7:0] idx, logic [7:0] exp);
    @(negedge clk_i);
    cfg_idx_i = idx;
    #1 check(tag, cfg_rdata_o, exp);
  endtask

  // expected item: {fwd, resp, data}
  task automatic io_read(string tag, logic [11:0] addr, logic fwd, logic resp, logic [7:0] data);
    @(negedge clk_i);
    io_rd_i = 1'b1; io_addr_i = addr;
    exp_q.push_back({fwd, resp, data}); tag_q.push_back(tag);
    @(negedge clk_i);
    io_rd_i = 1'b0;
  endtask

  // R11: config write and I/O read on the same edge
  task automatic write_and_read(string tag, logic [7:0] idx, logic [7:0] wdat,
                                logic [11:0] addr, logic fwd, logic resp, logic [7:0] data);
    @(negedge clk_i);
    cfg_wr_i = 1'b1; cfg_idx_i = idx; cfg_wdata_i = wdat;
    io_rd_i = 1'b1; io_addr_i = addr;
    exp_q.push_back({fwd, resp, data}); tag_q.push_back(tag);
    @(negedge clk_i);
    cfg_wr_i = 1'b0; io_rd_i = 1'b0;
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && io_vld_o) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R7 unexpected io_vld actual=1 expected=0");
      end else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " fwd/resp"}, {6'b0, dev_fwd_o, chk_resp_o}, {6'b0, e[9:8]});
        check({t, " data"}, chk_data_o, e[7:0]);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 / R9 / R10 reset state
    cfg_read("R1 act reset", 8'h30, 8'h00);
    cfg_read("R1 rchk reset", 8'h31, 8'h00);
    cfg_read("R1 irq reset", 8'h70, 8'h00);
    cfg_read("R1 dma reset", 8'h74, 8'h01);
    cfg_read("R9 itype", 8'h71, 8'h02);
    check("R1 irq_en reset", {7'b0, irq_en_o}, 8'h00);
    check("R10 dma_ch reset", {5'b0, dma_ch_o}, 8'h01);
    io_read("R7 no decode at reset", 12'h3F8, 1'b0, 1'b0, 8'h00);

    // R5 base programming
    cfg_write(8'h60, 8'h03);
    cfg_write(8'h61, 8'hFF);
    cfg_read("R5 base lsb low bits zero", 8'h61, 8'hF8);
    cfg_read("R5 base msb", 8'h60, 8'h03);
    io_read("R7 idle device ignored", 12'h3F8, 1'b0, 1'b0, 8'h00);

    // R3 test mode
    cfg_write(8'h31, 8'h03);
    cfg_read("R3 rchk readback", 8'h31, 8'h03);
    io_read("R3 pattern 55", 12'h3FA, 1'b0, 1'b1, 8'h55);
    io_read("R5 below window", 12'h3F7, 1'b0, 1'b0, 8'h00);
    io_read("R5 above window", 12'h400, 1'b0, 1'b0, 8'h00);
    cfg_write(8'h31, 8'h02);
    io_read("R3 pattern AA", 12'h3FF, 1'b0, 1'b1, 8'hAA);

    // R2 / R4 device on
    cfg_write(8'h30, 8'h01);
    io_read("R2 forward when on", 12'h3F8, 1'b1, 1'b0, 8'h00);
    cfg_write(8'h31, 8'h00);
    cfg_read("R4 disable allowed while on", 8'h31, 8'h00);
    cfg_write(8'h31, 8'h03);
    cfg_read("R4 enable rejected while on", 8'h31, 8'h00);
    io_read("R2 forward after reject", 12'h3FC, 1'b1, 1'b0, 8'h00);
    cfg_write(8'h30, 8'h00);
    io_read("R7 off and no test", 12'h3F8, 1'b0, 1'b0, 8'h00);

    // R11 same-cycle write and read
    cfg_write(8'h31, 8'h03);
    write_and_read("R11 read sees old state", 8'h30, 8'h01, 12'h3F9, 1'b0, 1'b1, 8'h55);
    io_read("R2 next read forwarded", 12'h3F9, 1'b1, 1'b0, 8'h00);
    write_and_read("R11 turn off same cycle", 8'h30, 8'h00, 12'h3F9, 1'b1, 1'b0, 8'h00);

    // R6 low base, top boundary
    cfg_write(8'h60, 8'h00);
    cfg_write(8'h61, 8'hF8);
    io_read("R6 base below 0x100", 12'h0F8, 1'b0, 1'b0, 8'h00);
    cfg_write(8'h60, 8'h0F);
    io_read("R5 top window", 12'hFFF, 1'b0, 1'b1, 8'h55);

    // R8 IRQ
    cfg_write(8'h70, 8'h05);
    cfg_read("R8 irq 5", 8'h70, 8'h05);
    check("R8 irq_en", {7'b0, irq_en_o}, 8'h01);
    check("R8 irq_num", {4'b0, irq_num_o}, 8'h05);
    cfg_write(8'h70, 8'h02);
    cfg_read("R8 code 2 rejected", 8'h70, 8'h05);
    cfg_write(8'h70, 8'h0C);
    cfg_read("R8 code 12 rejected", 8'h70, 8'h05);
    cfg_write(8'h70, 8'h0B);
    cfg_read("R8 code 11 accepted", 8'h70, 8'h0B);
    cfg_write(8'h70, 8'h03);
    check("R8 irq_num 3", {4'b0, irq_num_o}, 8'h03);
    cfg_write(8'h70, 8'h00);
    check("R8 code 0 clears", {7'b0, irq_en_o}, 8'h00);

    // R9 fixed and unassigned
    cfg_write(8'h71, 8'hFF);
    cfg_read("R9 itype write ignored", 8'h71, 8'h02);
    cfg_read("R9 unassigned index", 8'h50, 8'h00);

    // R10 DMA
    cfg_write(8'h74, 8'hFB);
    cfg_read("R10 dma readback", 8'h74, 8'h03);
    check("R10 dma_ch", {5'b0, dma_ch_o}, 8'h03);

    // R12 closed path
    @(negedge clk_i); cfg_en_i = 1'b0;
    cfg_write(8'h74, 8'h02);
    cfg_write(8'h30, 8'h01);
    @(negedge clk_i); cfg_en_i = 1'b1;
    cfg_read("R12 dma write ignored", 8'h74, 8'h03);
    cfg_read("R12 act write ignored", 8'h30, 8'h00);

    repeat (3) @(negedge clk_i);
    check("R7 scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule